// File: doc/BRIEF.md
# Card Response Capture FIFO

This block listens to the command line of a memory card after the controller has sent a command. It finds the start bit of the card's reply and shifts the reply in one bit per card clock. A 7-bit CRC is run over the reply as it arrives. The header and payload bits are packed into 16-bit halfwords and written into an eight-entry FIFO. The CRC field and the end bit are checked and then dropped.

Software drains the FIFO through a 32-bit read-only port. The halfword that arrived first is the most significant part of the reply, and it is the first one read out. Three status outputs report the result. One flags a CRC or end-bit error, one flags a missing reply, and one marks a reply as complete. Issuing the next command resets the pointers and all three flags.

The block runs entirely on the card clock. Command issue, data-line transfers and clock generation are outside it.

Top module: `rspcap_top`

## Requirements
- R1: After `cmdDone`, the first clock edge that samples `cmdLine` low is taken as bit 0 of the reply. The reply is 48 bits long if `longResp` was 0 at `cmdDone`, and 136 bits long if it was 1.
- R2: A 48-bit reply stores three halfwords, read in this order:
  - `{8'h00, bits 0..7}` (start bit, transmission bit and the 6-bit command index), with bit 0 in position 7;
  - bits 8..23;
  - bits 24..39.
  In every halfword the earlier bit sits in the more significant position.
- R3: A 136-bit reply stores bits 0..127 as eight halfwords. Halfword k holds bits 16k..16k+15, with the earliest bit in position 15, and halfword 0 is read first.
- R4: The seven CRC bits and the end bit are never written to the FIFO. Once all stored halfwords have been read, the next read returns zero.
- R5: The CRC is x^7+x^3+1, with the register starting at zero, computed over every bit that precedes the CRC field. `crcErr` is 1 when the received CRC differs from the computed one.
- R6: An end bit of 0 sets `crcErr`, even when the CRC matches.
- R7: `timeOut` is set when none of the 64 clock edges after `cmdDone` samples `cmdLine` low. In that case no halfword is stored and `respDone` stays 0. A start bit on the 64th edge is still accepted.
- R8: `rdData[31:16]` always reads as zero, and `rdData[15:0]` carries the halfword at the head of the FIFO.
- R9: Reset, and the cycle after `cmdDone`, leave `crcErr`, `timeOut` and `respDone` at 0 with the FIFO empty.
- R10: A read of an empty FIFO returns zero and does not move the read pointer.
- R11: `respDone` goes to 1 on the edge that samples the end bit. `crcErr` is valid from that point on, and both hold until the next `cmdDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; `cmdLine` is sampled on its rising edge |
| rstN | input | 1 | Active-low reset |
| cmdDone | input | 1 | Pulse on the edge of the command's end bit; clears the block and arms the reply search |
| longResp | input | 1 | Reply length selector captured at `cmdDone` (0 = 48 bits, 1 = 136 bits) |
| cmdLine | input | 1 | Serial command line from the card |
| rdEn | input | 1 | Pops the head halfword at the clock edge |
| rdData | output | 32 | Head halfword in bits 15:0, zero above; zero when empty |
| crcErr | output | 1 | CRC mismatch or bad end bit |
| timeOut | output | 1 | No start bit within the time-out window |
| respDone | output | 1 | A complete reply has been received |

## Verification
Several kinds of reply are captured, and each one separates a different fault:
- Short replies with different command indices and payloads show whether the header padding and the halfword order are right.
- A long reply that starts on the first edge after the command shows whether all eight entries are filled and the start is detected without delay.
- A flipped CRC bit and a zero end bit are injected separately, so each error source is shown to raise the flag on its own.
- The time-out is probed on the edge before the limit and on the limit edge, and a start bit is placed exactly on the last allowed edge.
- Reads issued while the FIFO is empty are followed by a real reply, which shows that those reads left the pointer where it was.

// File: rtl/rspcap_pkg.sv
package rspcap_pkg;
  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic clr;    // restart: empty FIFO, zero shifter and CRC
    logic shift;  // take one line bit into shifter and CRC
    logic push;   // write the shifter (with the current bit) into the FIFO
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2
  } capState_t;
endpackage

// File: rtl/rspcap_dp.sv
module rspcap_dp
  import rspcap_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int DEPTH    = 8,
  parameter int RD_W     = 32,
  parameter int CRC_W    = 7,
  parameter logic [CRC_W-1:0] CRC_POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic             cmdBit,
  input  logic             rdEn,
  output logic [RD_W-1:0]  rdData,
  output logic [CRC_W-1:0] crcRem
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [HALF_W-1:0] shiftReg, shiftNext;
  logic [CRC_W-1:0]  crcReg, crcNext;
  logic [HALF_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              notEmpty, popOk, fb;

  assign shiftNext = {shiftReg[HALF_W-2:0], cmdBit};
  assign fb        = cmdBit ^ crcReg[CRC_W-1];
  assign crcNext   = {crcReg[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  assign notEmpty  = (count != '0);
  assign popOk     = rdEn && notEmpty;
  assign crcRem    = crcReg;
  assign rdData    = notEmpty ? {{(RD_W-HALF_W){1'b0}}, mem[rdPtr]} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      crcReg   <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
    end else if (strb.clr) begin
      shiftReg <= '0;
      crcReg   <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
    end else begin
      if (strb.shift) begin
        shiftReg <= shiftNext;
        crcReg   <= crcNext;
      end
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (popOk)     rdPtr <= rdPtr + 1'b1;
      case ({strb.push, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push && !strb.clr) mem[wrPtr] <= shiftNext;
  end
endmodule

// File: rtl/rspcap_ctrl.sv
module rspcap_ctrl
  import rspcap_pkg::*;
#(
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136,
  parameter int TIMEOUT    = 64,
  parameter int HALF_W     = 16,
  parameter int CRC_W      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdDone,
  input  logic             longResp,
  input  logic             cmdBit,
  input  logic [CRC_W-1:0] crcRem,
  output dpStrobe_t        strb,
  output logic             crcErr,
  output logic             timeOut,
  output logic             respDone
);
  localparam int BIT_W       = $clog2(LONG_BITS + 1);
  localparam int TO_W        = $clog2(TIMEOUT);
  localparam int HB          = $clog2(HALF_W);
  localparam int SHORT_STORE = SHORT_BITS - CRC_W - 1;
  localparam int LONG_STORE  = LONG_BITS - CRC_W - 1;
  localparam logic [HB-1:0] SHORT_PHASE = HB'((SHORT_STORE - 1) % HALF_W);
  localparam logic [HB-1:0] LONG_PHASE  = HB'((LONG_STORE - 1) % HALF_W);

  capState_t         state;
  logic [BIT_W-1:0]  bitCnt, frameLast, storeLen;
  logic [TO_W-1:0]   waitCnt;
  logic              longMode, isLast, startSeen, inBody;
  logic [HB-1:0]     phase;

  assign frameLast = longMode ? BIT_W'(LONG_BITS - 1)  : BIT_W'(SHORT_BITS - 1);
  assign storeLen  = longMode ? BIT_W'(LONG_STORE)     : BIT_W'(SHORT_STORE);
  assign phase     = longMode ? LONG_PHASE : SHORT_PHASE;
  assign isLast    = (bitCnt == frameLast);

  always_comb begin
    startSeen  = (state == ST_WAIT) && !cmdBit && !cmdDone;
    inBody     = (state == ST_RECV) && !isLast && !cmdDone;
    strb       = '0;
    strb.clr   = cmdDone;
    strb.shift = startSeen || inBody;
    strb.push  = inBody && (bitCnt < storeLen) && (bitCnt[HB-1:0] == phase);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      waitCnt  <= '0;
      longMode <= 1'b0;
      crcErr   <= 1'b0;
      timeOut  <= 1'b0;
      respDone <= 1'b0;
    end else if (cmdDone) begin
      state    <= ST_WAIT;
      bitCnt   <= '0;
      waitCnt  <= '0;
      longMode <= longResp;
      crcErr   <= 1'b0;
      timeOut  <= 1'b0;
      respDone <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (!cmdBit) begin
            state  <= ST_RECV;
            bitCnt <= BIT_W'(1);
          end else if (waitCnt == TO_W'(TIMEOUT - 1)) begin
            timeOut <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_RECV: begin
          if (isLast) begin
            crcErr   <= (crcRem != '0) || !cmdBit;
            respDone <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rspcap_top.sv
module rspcap_top
  import rspcap_pkg::*;
#(
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136,
  parameter int TIMEOUT    = 64,
  parameter int HALF_W     = 16,
  parameter int DEPTH      = 8,
  parameter int RD_W       = 32,
  parameter int CRC_W      = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdDone,
  input  logic            longResp,
  input  logic            cmdLine,
  input  logic            rdEn,
  output logic [RD_W-1:0] rdData,
  output logic            crcErr,
  output logic            timeOut,
  output logic            respDone
);
  dpStrobe_t        strb;
  logic [CRC_W-1:0] crcRem;

  rspcap_ctrl #(
    .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS), .TIMEOUT(TIMEOUT),
    .HALF_W(HALF_W), .CRC_W(CRC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdDone(cmdDone), .longResp(longResp),
    .cmdBit(cmdLine), .crcRem(crcRem), .strb(strb),
    .crcErr(crcErr), .timeOut(timeOut), .respDone(respDone)
  );

  rspcap_dp #(
    .HALF_W(HALF_W), .DEPTH(DEPTH), .RD_W(RD_W), .CRC_W(CRC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdBit(cmdLine),
    .rdEn(rdEn), .rdData(rdData), .crcRem(crcRem)
  );
endmodule

// File: rtl/rspcap_chk.sv
module rspcap_chk #(
  parameter int RD_W   = 32,
  parameter int HALF_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdDone,
  input logic [RD_W-1:0] rdData,
  input logic            crcErr,
  input logic            timeOut,
  input logic            respDone
);
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdData[RD_W-1:HALF_W] == '0);

  assert_cmd_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> (!crcErr && !timeOut && !respDone && rdData == '0));

  assert_timeout_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(timeOut && respDone));

  assert_timeout_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (timeOut && !cmdDone) |=> timeOut);

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (respDone && !cmdDone) |=> (respDone && $stable(crcErr)));

  assert_err_needs_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> respDone);
endmodule

bind rspcap_top rspcap_chk #(.RD_W(RD_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdDone(cmdDone), .rdData(rdData),
  .crcErr(crcErr), .timeOut(timeOut), .respDone(respDone)
);

// File: tb/rspcap_top_test.sv
`timescale 1ns/1ps
module rspcap_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdDone = 1'b0;
  logic        longResp = 1'b0;
  logic        cmdLine = 1'b1;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        crcErr, timeOut, respDone;

  int checks = 0;
  int errors = 0;
  logic        frame [0:135];
  int          nb;
  logic [15:0] expQ [$];

  always #4 clk = ~clk;

  rspcap_top uut (
    .clk(clk), .rstN(rstN), .cmdDone(cmdDone), .longResp(longResp),
    .cmdLine(cmdLine), .rdEn(rdEn), .rdData(rdData),
    .crcErr(crcErr), .timeOut(timeOut), .respDone(respDone)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // build a reply frame from the rules (header, payload, CRC, end bit)
  task automatic buildFrame(input bit isLong, input logic [5:0] idx,
                            input logic [119:0] pay, input bit flipCrc,
                            input bit badEnd);
    logic [6:0] c;
    int payBits;
    nb = isLong ? 136 : 48;
    payBits = isLong ? 120 : 32;
    frame[0] = 1'b0;
    frame[1] = 1'b0;
    for (int j = 0; j < 6; j++) frame[2+j] = isLong ? 1'b1 : idx[5-j];
    for (int j = 0; j < payBits; j++) frame[8+j] = pay[payBits-1-j];
    c = '0;
    for (int j = 0; j < nb - 8; j++) begin
      logic f;
      f = frame[j] ^ c[6];
      c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
    end
    for (int j = 0; j < 7; j++) frame[nb-8+j] = c[6-j];
    if (flipCrc) frame[nb-8] = ~frame[nb-8];
    frame[nb-1] = ~badEnd;
  endtask

  function automatic logic [15:0] packBits(input int first, input int len);
    logic [15:0] h = '0;
    for (int j = 0; j < len; j++) h = {h[14:0], frame[first+j]};
    return h;
  endfunction

  // driver side of the scoreboard: queue the halfwords the reply must yield
  task automatic queueExpected();
    if (nb == 48) begin
      expQ.push_back(packBits(0, 8));
      expQ.push_back(packBits(8, 16));
      expQ.push_back(packBits(24, 16));
    end else begin
      for (int k = 0; k < 8; k++) expQ.push_back(packBits(16*k, 16));
    end
  endtask

  task automatic issueCmd(input bit isLong);
    @(negedge clk);
    cmdDone = 1'b1;
    longResp = isLong;
    cmdLine = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
  endtask

  // gap high edges, then the frame; returns at the negedge after the end bit
  task automatic sendFrame(input int gap);
    for (int k = 0; k < gap; k++) begin
      cmdLine = 1'b1;
      @(negedge clk);
    end
    for (int i = 0; i < nb; i++) begin
      cmdLine = frame[i];
      @(negedge clk);
    end
    cmdLine = 1'b1;
  endtask

  // monitor side: pop and compare each halfword, then require an empty read
  task automatic drainCheck(input string req);
    while (expQ.size() > 0) begin
      logic [15:0] e;
      e = expQ.pop_front();
      check(rdData == {16'h0, e}, req, rdData, {16'h0, e});
      rdEn = 1'b1;
      @(negedge clk);
      rdEn = 1'b0;
    end
    check(rdData == 32'h0, "R4 nothing after payload", rdData, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(rdData == 0, "R9 reset rdData", rdData, 0);
    check({crcErr, timeOut, respDone} == 3'b000, "R9 reset flags",
          {29'h0, crcErr, timeOut, respDone}, 0);

    // R2 short reply, R8 upper half zero, R5 good CRC, R11 done
    issueCmd(1'b0);
    buildFrame(1'b0, 6'h11, 120'hDEADBEEF, 1'b0, 1'b0);
    queueExpected();
    sendFrame(3);
    check(respDone == 1'b1, "R11 done after end bit", respDone, 1);
    check(crcErr == 1'b0, "R5 good CRC", crcErr, 0);
    check(timeOut == 1'b0, "R7 no timeout", timeOut, 0);
    drainCheck("R2 short halfword R8");

    // R10 empty reads do not move the pointer
    issueCmd(1'b0);
    rdEn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check(rdData == 0, "R10 empty read", rdData, 0);
      @(negedge clk);
    end
    rdEn = 1'b0;
    buildFrame(1'b0, 6'h2A, 120'h12345678, 1'b0, 1'b0);
    queueExpected();
    sendFrame(0);
    drainCheck("R10 data after empty reads");

    // R3 long reply, start on first edge (R1)
    issueCmd(1'b1);
    buildFrame(1'b1, 6'h00, 120'h0123456789ABCDEF_FEDCBA98765432, 1'b0, 1'b0);
    queueExpected();
    sendFrame(0);
    check(respDone == 1'b1, "R1 long frame length", respDone, 1);
    check(crcErr == 1'b0, "R5 long good CRC", crcErr, 0);
    drainCheck("R3 long halfword");

    // R5 corrupted CRC bit
    issueCmd(1'b0);
    buildFrame(1'b0, 6'h05, 120'hA5A5_0F0F, 1'b1, 1'b0);
    sendFrame(1);
    check(crcErr == 1'b1, "R5 CRC mismatch", crcErr, 1);
    check(respDone == 1'b1, "R11 done with error", respDone, 1);

    // R9 a new command clears flags and unread data
    issueCmd(1'b0);
    check({crcErr, timeOut, respDone} == 3'b000, "R9 clear flags",
          {29'h0, crcErr, timeOut, respDone}, 0);
    check(rdData == 0, "R9 clear FIFO", rdData, 0);

    // R6 bad end bit with correct CRC
    buildFrame(1'b0, 6'h3C, 120'h0000_FFFF, 1'b0, 1'b1);
    sendFrame(0);
    check(crcErr == 1'b1, "R6 end bit zero", crcErr, 1);

    // R7 time-out: not set after 63 edges, set after 64, late start ignored
    issueCmd(1'b0);
    for (int k = 0; k < 63; k++) begin
      cmdLine = 1'b1;
      @(negedge clk);
    end
    check(timeOut == 1'b0, "R7 timeout edge 63", timeOut, 0);
    @(negedge clk);
    check(timeOut == 1'b1, "R7 timeout edge 64", timeOut, 1);
    buildFrame(1'b0, 6'h01, 120'h11112222, 1'b0, 1'b0);
    sendFrame(2);
    check(respDone == 1'b0, "R7 no reply after timeout", respDone, 0);
    check(rdData == 0, "R7 nothing stored", rdData, 0);
    check(timeOut == 1'b1, "R7 timeout held", timeOut, 1);

    // R7 start bit on the 64th edge is accepted
    issueCmd(1'b0);
    buildFrame(1'b0, 6'h3F, 120'hCAFE_F00D, 1'b0, 1'b0);
    queueExpected();
    sendFrame(63);
    check(timeOut == 1'b0, "R7 last edge start", timeOut, 0);
    check(respDone == 1'b1, "R7 last edge done", respDone, 1);
    drainCheck("R7 last edge data");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule